// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A free-running reference enable (nominally one pulse per cycle of a 32.768 kHz source) is counted down to a one-second strobe. On each strobe the seconds field advances, and carries ripple upward through every field within that single cycle. Day-of-month roll-over follows the real length of each month, including a 29th of February in leap years.

The hour byte carries its own format. In 24-hour form it counts 00 to 23. In 12-hour form it counts 12, 01 … 11 and has a PM flag. A host bus loads any single field through a synchronous write port. Any write also restarts the sub-second divider, so the first strobe after a load comes one full second later. Switching between hour formats is done by writing the hour byte with the desired format bit.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, sec_o=00, min_o=00, hour_o=00 (24-hour form), wday_o=01, date_o=01, month_o=01, year_o=00, and sec_strobe is low.
- R2: Seconds and minutes count 00 to 59 in BCD. A value of 59 returns to 00 and advances the next field in the same update.
- R3: With hour bit 6 clear (24-hour form), bits 5:0 hold BCD 00 to 23. An advance from 23 gives 00 and advances the day (weekday and date).
- R4: With hour bit 6 set (12-hour form), bit 5 is the PM flag and bits 4:0 hold BCD 01 to 12. The order is 12, 01, …, 11, 12. The PM flag toggles on 11 to 12, and 12 goes to 01 with the flag unchanged.
- R5: In 12-hour form the day advances only on the step from 11 PM to 12 AM, never on the step from 11 AM to 12 PM.
- R6: The date returns to 01 and advances the month after the last day of the month. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months. For month 02 it is 29 when the BCD year is divisible by 4 (00 included) and 28 otherwise.
- R7: The weekday counts 1 to 7, advances whenever the date advances, and goes from 7 to 1.
- R8: The month goes from 12 to 01 and advances the year. The year goes from 99 to 00.
- R9: sec_strobe is a one-cycle pulse after every DIV cycles with ref_en high; cycles with ref_en low do not count. The fields take their new values at the clock edge that ends the strobe cycle.
- R10: When wr_en is high, wr_data is loaded at the next edge into the field selected by wr_sel (0 sec, 1 min, 2 hour, 3 wday, 4 date, 5 month, 6 year). The divider restarts, so the next strobe is seen DIV ref_en cycles after the last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Reference enable, one pulse per reference period |
| wr_en | input | 1 | Host field write strobe |
| wr_sel | input | 3 | Field select for a write |
| wr_data | input | 8 | Packed BCD value to load |
| sec_strobe | output | 1 | One-second pulse, one cycle wide |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with format bit 6 and PM bit 5 |
| wday_o | output | 8 | Weekday 1 to 7 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year 00 to 99, BCD |

## Verification
The calendar is loaded just before each boundary and then clocked through it:

- Ends of 30-day and 31-day months, February in a common year, a leap year and year 00, and the end of the century. These separate the month-length table from the leap rule.
- 12-hour loads at 11 AM, 11 PM, 12 AM and 12 PM. These distinguish the noon step from the midnight step and confirm that the PM flag, not the hour digits alone, decides the day carry.
- A run of over a hundred seconds, which exercises the seconds and minutes carries through several minutes.
- Strobe spacing measured after a load, with and without a pause in ref_en. This tells divider restart apart from plain reference counting.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_WDAY  = 3'd3,
    FLD_DATE  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6
  } rtc_field_e;

  localparam int NUM_FIELDS = 7;

  // Two-digit BCD increment; the caller handles wrap.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic year_is_leap(input logic [7:0] yr);
    logic [6:0] bin;
    bin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    return (bin[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return year_is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_en,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (ref_en) begin
        if (cnt == LAST) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_tick_single_R9: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  assert_write_restart_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> !tick);

endmodule

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap
  import rtc_pkg::*;
#(
  parameter logic [7:0] LO      = 8'h00,
  parameter logic [7:0] HI      = 8'h59,
  parameter logic [7:0] RST_VAL = LO
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       wr,
  input  logic [7:0] wr_val,
  output logic [7:0] val,
  output logic       carry
);
  always_ff @(posedge clk) begin
    if (rst)       val <= RST_VAL;
    else if (wr)   val <= wr_val;
    else if (step) val <= (val == HI) ? LO : bcd_inc(val);
  end

  assign carry = step && (val == HI);

  assert_wrap_to_low_R2: assert property (@(posedge clk) disable iff (rst)
    (step && !wr && val == HI) |=> (val == LO));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!step && !wr) |=> $stable(val));

endmodule

// File: rtl/rtc_hour_unit.sv
module rtc_hour_unit
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       wr,
  input  logic [7:0] wr_val,
  output logic [7:0] hr,
  output logic       carry
);
  logic [7:0] nxt, inc24, inc12;
  logic       mode12, pm;

  assign mode12 = hr[6];
  assign pm     = hr[5];

  always_comb begin
    inc24 = bcd_inc({2'b00, hr[5:0]});
    inc12 = bcd_inc({3'b000, hr[4:0]});
    if (!mode12)                nxt = (hr[5:0] == 6'h23) ? 8'h00 : {2'b00, inc24[5:0]};
    else if (hr[4:0] == 5'h11)  nxt = {2'b01, ~pm, 5'h12};
    else if (hr[4:0] == 5'h12)  nxt = {2'b01, pm, 5'h01};
    else                        nxt = {2'b01, pm, inc12[4:0]};
  end

  always_ff @(posedge clk) begin
    if (rst)       hr <= 8'h00;
    else if (wr)   hr <= wr_val;
    else if (step) hr <= nxt;
  end

  assign carry = step && (mode12 ? (pm && hr[4:0] == 5'h11) : (hr[5:0] == 6'h23));

  assert_pm_flip_R4: assert property (@(posedge clk) disable iff (rst)
    (step && !wr && mode12 && hr[4:0] == 5'h11) |=> (hr[5] != $past(hr[5])));

  assert_midnight_day_R5: assert property (@(posedge clk) disable iff (rst)
    carry |=> (hr[6] ? (hr[5:0] == 6'h12) : (hr[5:0] == 6'h00)));

  assert_format_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !wr) |=> $stable(hr[6]));

endmodule

// File: rtl/rtc_date_unit.sv
module rtc_date_unit
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       wr,
  input  logic [7:0] wr_val,
  input  logic [7:0] month,
  input  logic [7:0] year,
  output logic [7:0] date,
  output logic       carry
);
  logic [7:0] last;

  assign last  = last_day(month, year);
  assign carry = step && (date == last);

  always_ff @(posedge clk) begin
    if (rst)       date <= 8'h01;
    else if (wr)   date <= wr_val;
    else if (step) date <= (date == last) ? 8'h01 : bcd_inc(date);
  end

  assert_date_restart_R6: assert property (@(posedge clk) disable iff (rst)
    carry |=> (date == 8'h01));

  assert_feb_short_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !wr && month == 8'h02 && date == 8'h28 && !year_is_leap(year))
      |=> (date == 8'h01));

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int DIV = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_en,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic       sec_strobe,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);
  logic                  tick, adv;
  logic [NUM_FIELDS-1:0] hit;
  logic c_sec, c_min, c_hour, c_wday, c_date, c_month, c_year;

  rtc_prescaler #(.DIV(DIV)) u_div (
    .clk(clk), .rst(rst), .ref_en(ref_en), .clr(wr_en), .tick(tick)
  );

  assign sec_strobe = tick;
  assign adv        = tick & ~wr_en;

  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) hit[i] = wr_en && (wr_sel == 3'(i));
  end

  rtc_bcd_wrap #(.LO(8'h00), .HI(8'h59)) u_sec (
    .clk(clk), .rst(rst), .step(adv), .wr(hit[FLD_SEC]), .wr_val(wr_data),
    .val(sec_o), .carry(c_sec));

  rtc_bcd_wrap #(.LO(8'h00), .HI(8'h59)) u_min (
    .clk(clk), .rst(rst), .step(c_sec), .wr(hit[FLD_MIN]), .wr_val(wr_data),
    .val(min_o), .carry(c_min));

  rtc_hour_unit u_hour (
    .clk(clk), .rst(rst), .step(c_min), .wr(hit[FLD_HOUR]), .wr_val(wr_data),
    .hr(hour_o), .carry(c_hour));

  rtc_bcd_wrap #(.LO(8'h01), .HI(8'h07)) u_wday (
    .clk(clk), .rst(rst), .step(c_hour), .wr(hit[FLD_WDAY]), .wr_val(wr_data),
    .val(wday_o), .carry(c_wday));

  rtc_date_unit u_date (
    .clk(clk), .rst(rst), .step(c_hour), .wr(hit[FLD_DATE]), .wr_val(wr_data),
    .month(month_o), .year(year_o), .date(date_o), .carry(c_date));

  rtc_bcd_wrap #(.LO(8'h01), .HI(8'h12)) u_month (
    .clk(clk), .rst(rst), .step(c_date), .wr(hit[FLD_MONTH]), .wr_val(wr_data),
    .val(month_o), .carry(c_month));

  rtc_bcd_wrap #(.LO(8'h00), .HI(8'h99)) u_year (
    .clk(clk), .rst(rst), .step(c_month), .wr(hit[FLD_YEAR]), .wr_val(wr_data),
    .val(year_o), .carry(c_year));

  assert_century_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    c_year |=> (year_o == 8'h00 && month_o == 8'h01));

  assert_week_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    c_wday |=> (wday_o == 8'h01));

  assert_weekday_with_date_R7: assert property (@(posedge clk) disable iff (rst)
    c_hour |=> (wday_o != $past(wday_o)));

  assert_write_lands_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 3'd0) |=> (sec_o == $past(wr_data)));

endmodule

// File: tb/bcd_rtc_core_bench.sv
module bcd_rtc_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0, rst = 1'b1, ref_en = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic sec_strobe;
  logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;

  bcd_rtc_core #(.DIV(DIV)) u_bcd_rtc_core (
    .clk(clk), .rst(rst), .ref_en(ref_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sec_strobe(sec_strobe), .sec_o(sec_o), .min_o(min_o),
    .hour_o(hour_o), .wday_o(wday_o), .date_o(date_o), .month_o(month_o),
    .year_o(year_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;

  // Reference model in plain binary
  int m_s, m_m, m_h, m_wd, m_d, m_mo, m_y;
  bit m_pm, m_12;

  logic [55:0] exp_q[$];
  string       tag_q[$];
  logic [55:0] mon_e;
  string       mon_t;
  bit          pend = 1'b0;

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [55:0] model_vec();
    logic [7:0] hb, hv;
    hv = bcd(m_h);
    hb = m_12 ? {2'b01, m_pm, hv[4:0]} : hv;
    return {bcd(m_s), bcd(m_m), hb, bcd(m_wd), bcd(m_d), bcd(m_mo), bcd(m_y)};
  endfunction

  function automatic logic [55:0] cur_vec();
    return {sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o};
  endfunction

  task automatic model_step();
    bit day = 1'b0;
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_m++;
      if (m_m == 60) begin
        m_m = 0;
        if (!m_12) begin
          m_h++;
          if (m_h == 24) begin m_h = 0; day = 1'b1; end
        end else if (m_h == 11) begin
          m_h = 12; if (m_pm) day = 1'b1; m_pm = !m_pm;
        end else if (m_h == 12) m_h = 1;
        else m_h++;
      end
    end
    if (day) begin
      m_wd = (m_wd == 7) ? 1 : m_wd + 1;
      m_d++;
      if (m_d > mdays(m_mo, m_y)) begin
        m_d = 1; m_mo++;
        if (m_mo > 12) begin m_mo = 1; m_y = (m_y + 1) % 100; end
      end
    end
  endtask

  task automatic check(input string tag, input logic [55:0] act, input logic [55:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compare after every strobe-driven update
  always @(negedge clk) begin
    if (pend) begin
      pend = 1'b0;
      if (exp_q.size() > 0) begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        check(mon_t, cur_vec(), mon_e);
      end
    end
    if (sec_strobe) pend = 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG) begin
      checks++; errors++;
      $display("FAIL watchdog (R9 strobe flow): actual %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic write_one(input int sel, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = v;
  endtask

  task automatic load_all(input int s, input int m, input int h, input bit pm,
                          input bit t12, input int wd, input int d, input int mo,
                          input int y);
    logic [55:0] v;
    m_s = s; m_m = m; m_h = h; m_pm = pm; m_12 = t12;
    m_wd = wd; m_d = d; m_mo = mo; m_y = y;
    v = model_vec();
    for (int i = 0; i < 7; i++) write_one(i, v[55 - 8*i -: 8]);
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 write visible", cur_vec(), model_vec());
  endtask

  task automatic run_ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      model_step();
      exp_q.push_back(model_vec());
      tag_q.push_back(tag);
    end
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset fields", cur_vec(), {8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00});
    check("R1 reset strobe", {55'd0, sec_strobe}, 56'd0);
    ref_en = 1'b1;

    // R9 / R10: strobe spacing after a load
    load_all(10, 0, 0, 0, 0, 1, 1, 1, 1);
    n = 0;
    while (!sec_strobe) begin @(negedge clk); n++; end
    check("R10 strobe after write", 56'(n), 56'(DIV));
    model_step();
    repeat (2) @(negedge clk);
    run_ticks(3, "R9 update per strobe");

    // R9: paused reference does not count
    load_all(20, 5, 3, 0, 0, 2, 2, 2, 2);
    ref_en = 1'b0;
    n = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); n++; end
    ref_en = 1'b1;
    while (!sec_strobe) begin @(negedge clk); n++; end
    check("R9 strobe with paused ref", 56'(n), 56'(DIV + 10));
    model_step();
    repeat (2) @(negedge clk);
    run_ticks(1, "R9 after pause");

    // Carries and calendar boundaries
    load_all(58, 59, 23, 0, 0, 7, 31, 12, 99); run_ticks(5, "R8 century wrap");
    load_all(59, 59, 23, 0, 0, 3, 14, 5, 20);  run_ticks(2, "R3 24h midnight");
    load_all(59, 59, 23, 0, 0, 7, 10, 3, 15);  run_ticks(1, "R7 weekday wrap");
    load_all(59, 59, 23, 0, 0, 1, 28, 2, 23);  run_ticks(1, "R6 Feb common");
    load_all(59, 59, 23, 0, 0, 1, 28, 2, 24);  run_ticks(1, "R6 Feb leap 28");
    load_all(59, 59, 23, 0, 0, 1, 29, 2, 24);  run_ticks(1, "R6 Feb leap 29");
    load_all(59, 59, 23, 0, 0, 4, 28, 2, 0);   run_ticks(1, "R6 Feb year 00");
    load_all(59, 59, 23, 0, 0, 5, 30, 4, 21);  run_ticks(1, "R6 April end");
    load_all(59, 59, 23, 0, 0, 5, 30, 1, 21);  run_ticks(1, "R6 January 30");
    load_all(59, 59, 23, 0, 0, 6, 30, 11, 21); run_ticks(1, "R6 November end");
    load_all(59, 59, 23, 0, 0, 6, 30, 9, 22);  run_ticks(1, "R6 September end");

    // 12-hour form
    load_all(59, 59, 11, 0, 1, 4, 15, 6, 10); run_ticks(2, "R5 noon keeps date");
    load_all(58, 59, 11, 1, 1, 2, 15, 6, 10); run_ticks(3, "R5 midnight advances");
    load_all(59, 59, 12, 1, 1, 2, 15, 6, 10); run_ticks(1, "R4 12 PM to 1 PM");
    load_all(59, 59, 12, 0, 1, 2, 15, 6, 10); run_ticks(1, "R4 12 AM to 1 AM");
    load_all(59, 59, 9, 1, 1, 2, 15, 6, 10);  run_ticks(1, "R4 plain hour step");

    // Long run through minutes and an hour
    load_all(0, 58, 0, 0, 0, 1, 1, 1, 0); run_ticks(130, "R2 seconds minutes");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule